// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block arbitrates among eight interrupt request lines. It keeps a pending register fed by the lines, an in-service register for the levels the processor is handling, and a mask register. Each cycle it finds the highest-priority pending level that is not masked. It compares that level against the highest in-service level under the current priority order. When the pending level ranks higher, it raises an interrupt output.

A command decoder outside the block drives it through single-cycle strobes: an initialization pulse that carries the trigger and auto-clear mode bits, mask writes, special-mask writes, and a 3-bit command that selects an end-of-interrupt or priority-rotation action. An acknowledge sequencer drives two more strobes. The commit pulse moves the winning level from pending to in-service and reports that level. The final pulse ends the sequence, which matters in automatic end-of-interrupt mode.

Priority is circular. A base register holds the level that currently ranks lowest, and the level after it, modulo eight, ranks highest. Rotation commands and the automatic-rotate option move the base. Bus decoding and vector formatting belong to neighbouring blocks.

Top module: `rot_irq_resolver`

## Requirements
- R1: After reset or an initialization pulse, the pending, in-service and mask registers read zero and the interrupt output is low. Level 0 ranks highest and level 7 lowest. Initialization also clears special mask mode, the auto-rotate flag and the edge history, so a line already high at initialization is not latched until it has been seen low.
- R2: Two clock edges after the state settles, `int_o` is high exactly when the highest-priority unmasked pending level outranks every in-service level that arbitration sees.
- R3: A set bit i in the mask blocks only line i. `win_lvl` shows the highest-priority unmasked pending level, and that level may rank below the masked one.
- R4: An `ack_commit` pulse while an interrupt is due sets the winner's in-service bit, clears its pending bit, and loads the winner into `ack_lvl`.
- R5: Command code 1 is a non-specific end-of-interrupt. It clears the highest-priority in-service bit. In special mask mode it skips in-service bits whose mask bit is set.
- R6: Command code 2 is a specific end-of-interrupt. It clears the in-service bit that `cmd_lvl` selects.
- R7: The following commands change priority. After any of them, the level one above the new lowest level, modulo 8, ranks highest.
  - Code 3 clears the highest-priority in-service bit and makes that level the lowest.
  - Code 4 clears the in-service bit that `cmd_lvl` selects and makes that level the lowest.
  - Code 5 makes `cmd_lvl` the lowest and leaves the in-service register unchanged.
- R8: While special mask mode is on, any in-service or pending bit whose mask bit is set counts as clear during arbitration, so lower levels can nest.
- R9: In edge mode (initialization with `init_level_trig`=0), a line is latched on a low-to-high change. A pending bit drops when its line drops. A line held high is not latched again after its pending bit was committed.
- R10: In level mode (`init_level_trig`=1), a high line counts as a request on its own. A line still high after commit is pending again.
- R11: An `ack_commit` pulse while no interrupt is due loads 7 into `ack_lvl` and sets no in-service bit.
- R12: In automatic end-of-interrupt mode (initialization with `init_auto_eoi`=1), `ack_final` clears the highest-priority in-service bit. If the auto-rotate flag is set, that level also becomes the lowest. Command code 6 sets the auto-rotate flag and code 7 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NLVL | Interrupt request lines |
| init_pulse | input | 1 | Initialization strobe |
| init_level_trig | input | 1 | Trigger mode loaded at initialization (1 = level) |
| init_auto_eoi | input | 1 | Automatic end-of-interrupt loaded at initialization |
| mask_wr | input | 1 | Mask register write strobe |
| mask_data | input | NLVL | New mask value |
| smm_wr | input | 1 | Special mask mode write strobe |
| smm_val | input | 1 | New special mask mode value |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 none, 1..7 as in R5, R6, R7, R12) |
| cmd_lvl | input | log2(NLVL) | Level operand of a command |
| ack_commit | input | 1 | Acknowledge commit pulse |
| ack_final | input | 1 | Last acknowledge pulse |
| int_o | output | 1 | Interrupt output |
| win_lvl | output | log2(NLVL) | Highest unmasked pending level (7 when none) |
| ack_lvl | output | log2(NLVL) | Level reported at the last commit |
| irr_o | output | NLVL | Pending register |
| isr_o | output | NLVL | In-service register |
| imr_o | output | NLVL | Mask register |

## Verification
The hardest situation to reach is two in-service levels where one is hidden by the mask under special mask mode. The stimulus gets there by committing a level, then masking it. It turns special mask mode on, raises a lower line and commits it as a nested level. A non-specific end-of-interrupt must then clear the nested level and not the masked one. The priority base is checked by sweeping all eight lowest-level settings with every line high and watching which level wins before and after a rotating end-of-interrupt. The full-nesting rule is checked over all 64 pairs of an in-service level and a new request.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_EOI_ANY  = 3'd1,
    OP_EOI_LVL  = 3'd2,
    OP_ROT_ANY  = 3'd3,
    OP_ROT_LVL  = 3'd4,
    OP_SET_LOW  = 3'd5,
    OP_AROT_ON  = 3'd6,
    OP_AROT_OFF = 3'd7
  } res_op_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Circular priority finder: index low+1 ranks highest, index low ranks lowest.
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic [LW-1:0] lvl,
  output logic          vld
);
  logic [LW-1:0] idx;

  always_comb begin
    vld = 1'b0;
    lvl = LW'(N - 1);
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = low + LW'(k + 1);
      if (vec[idx]) begin
        vld = 1'b1;
        lvl = idx;
      end
    end
  end
endmodule

// File: rtl/irq_request_reg.sv
// Pending-request register with edge or level capture.
module irq_request_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         level_mode,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] armed_q;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      armed_q <= '0;
      irr     <= '0;
    end else begin
      armed_q <= ~irq;
      if (level_mode) irr <= irq & ~clr;
      else            irr <= irq & (irr | armed_q) & ~clr;
    end
  end

  // R9: a pending bit only exists while its line was high on the previous edge
  a_r9_irr_tracks_line: assert property (@(posedge clk) disable iff (rst)
    (irr & ~$past(irq)) == '0);
endmodule

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver
  import irq_res_pkg::*;
#(
  parameter int NLVL = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NLVL-1:0]           irq_in,
  input  logic                      init_pulse,
  input  logic                      init_level_trig,
  input  logic                      init_auto_eoi,
  input  logic                      mask_wr,
  input  logic [NLVL-1:0]           mask_data,
  input  logic                      smm_wr,
  input  logic                      smm_val,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(NLVL)-1:0]   cmd_lvl,
  input  logic                      ack_commit,
  input  logic                      ack_final,
  output logic                      int_o,
  output logic [$clog2(NLVL)-1:0]   win_lvl,
  output logic [$clog2(NLVL)-1:0]   ack_lvl,
  output logic [NLVL-1:0]           irr_o,
  output logic [NLVL-1:0]           isr_o,
  output logic [NLVL-1:0]           imr_o
);
  localparam int LW = $clog2(NLVL);
  localparam logic [LW-1:0] LAST = LW'(NLVL - 1);

  logic [NLVL-1:0] irr, isr_q, imr_q, isr_nxt, clr_irr, eff_irr, isr_view;
  logic [LW-1:0]   low_q, low_nxt, req_lvl, srv_lvl, req_rank, srv_rank;
  logic            req_vld, srv_vld, int_now;
  logic            smm_q, arot_q, lvl_mode_q, aeoi_q;
  res_op_e         op;

  assign op = res_op_e'(cmd_op);

  irq_request_reg #(.N(NLVL)) u_req_reg (
    .clk        (clk),
    .rst        (rst),
    .init       (init_pulse),
    .level_mode (lvl_mode_q),
    .irq        (irq_in),
    .clr        (clr_irr),
    .irr        (irr)
  );

  assign eff_irr  = irr & ~imr_q;
  assign isr_view = smm_q ? (isr_q & ~imr_q) : isr_q;

  irq_prio_pick #(.N(NLVL), .LW(LW)) u_pick_req (
    .vec (eff_irr), .low (low_q), .lvl (req_lvl), .vld (req_vld)
  );

  irq_prio_pick #(.N(NLVL), .LW(LW)) u_pick_srv (
    .vec (isr_view), .low (low_q), .lvl (srv_lvl), .vld (srv_vld)
  );

  // Rank 0 is the highest priority.
  assign req_rank = req_lvl - low_q - LW'(1);
  assign srv_rank = srv_lvl - low_q - LW'(1);
  assign int_now  = req_vld && (!srv_vld || (req_rank < srv_rank));

  always_comb begin
    clr_irr = '0;
    if (ack_commit && int_now) clr_irr[req_lvl] = 1'b1;
  end

  always_comb begin
    isr_nxt = isr_q;
    low_nxt = low_q;
    if (ack_commit && int_now) isr_nxt[req_lvl] = 1'b1;
    if (ack_final && aeoi_q && srv_vld) begin
      isr_nxt[srv_lvl] = 1'b0;
      if (arot_q) low_nxt = srv_lvl;
    end
    if (cmd_valid) begin
      case (op)
        OP_EOI_ANY: if (srv_vld) isr_nxt[srv_lvl] = 1'b0;
        OP_EOI_LVL: isr_nxt[cmd_lvl] = 1'b0;
        OP_ROT_ANY: if (srv_vld) begin
          isr_nxt[srv_lvl] = 1'b0;
          low_nxt          = srv_lvl;
        end
        OP_ROT_LVL: begin
          isr_nxt[cmd_lvl] = 1'b0;
          low_nxt          = cmd_lvl;
        end
        OP_SET_LOW: low_nxt = cmd_lvl;
        default: ;
      endcase
    end
    if (init_pulse) begin
      isr_nxt = '0;
      low_nxt = LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q      <= '0;
      imr_q      <= '0;
      low_q      <= LAST;
      smm_q      <= 1'b0;
      arot_q     <= 1'b0;
      lvl_mode_q <= 1'b0;
      aeoi_q     <= 1'b0;
      int_o      <= 1'b0;
      win_lvl    <= LAST;
      ack_lvl    <= LAST;
    end else begin
      isr_q   <= isr_nxt;
      low_q   <= low_nxt;
      int_o   <= int_now;
      win_lvl <= req_lvl;
      if (ack_commit) ack_lvl <= int_now ? req_lvl : LAST;
      if (init_pulse) begin
        imr_q      <= '0;
        smm_q      <= 1'b0;
        arot_q     <= 1'b0;
        lvl_mode_q <= init_level_trig;
        aeoi_q     <= init_auto_eoi;
      end else begin
        if (mask_wr) imr_q <= mask_data;
        if (smm_wr)  smm_q <= smm_val;
        if (cmd_valid && op == OP_AROT_ON)  arot_q <= 1'b1;
        if (cmd_valid && op == OP_AROT_OFF) arot_q <= 1'b0;
      end
    end
  end

  assign irr_o = irr;
  assign isr_o = isr_q;
  assign imr_o = imr_q;

  // R2: an interrupt is only raised for an unmasked pending request
  a_r2_int_unmasked: assert property (@(posedge clk) disable iff (rst)
    int_o |-> $past(|(irr & ~imr_q)));

  // R4: a due commit leaves the winner in service
  a_r4_commit_sets_isr: assert property (@(posedge clk) disable iff (rst)
    (ack_commit && int_now && !init_pulse && !cmd_valid && !ack_final)
      |=> isr_q[$past(req_lvl)]);

  // R6: specific end-of-interrupt clears the named level
  a_r6_specific_clear: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd2 && !ack_commit && !init_pulse)
      |=> !isr_q[$past(cmd_lvl)]);

  // R7: the priority base moves only on a command, a final pulse or init
  a_r7_base_moves_on_cmd: assert property (@(posedge clk) disable iff (rst)
    !$stable(low_q) |-> $past(cmd_valid || ack_final || init_pulse));

  // R11: a commit with nothing due reports the default level
  a_r11_default_level: assert property (@(posedge clk) disable iff (rst)
    (ack_commit && !int_now) |=> ack_lvl == LAST);

  // R12: automatic end-of-interrupt empties a single in-service level
  a_r12_auto_clear: assert property (@(posedge clk) disable iff (rst)
    (ack_final && aeoi_q && !smm_q && !ack_commit && !cmd_valid && !init_pulse
      && $countones(isr_q) == 1) |=> isr_q == '0);
endmodule

// File: tb/rot_irq_resolver_tb.sv
module rot_irq_resolver_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq_in;
  logic init_pulse, init_level_trig, init_auto_eoi;
  logic mask_wr, smm_wr, smm_val, cmd_valid, ack_commit, ack_final;
  logic [N-1:0] mask_data;
  logic [2:0] cmd_op, cmd_lvl;
  logic int_o;
  logic [2:0] win_lvl, ack_lvl;
  logic [N-1:0] irr_o, isr_o, imr_o;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rot_irq_resolver #(.NLVL(N)) dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .init_pulse(init_pulse), .init_level_trig(init_level_trig),
    .init_auto_eoi(init_auto_eoi), .mask_wr(mask_wr), .mask_data(mask_data),
    .smm_wr(smm_wr), .smm_val(smm_val), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_lvl(cmd_lvl), .ack_commit(ack_commit),
    .ack_final(ack_final), .int_o(int_o), .win_lvl(win_lvl),
    .ack_lvl(ack_lvl), .irr_o(irr_o), .isr_o(isr_o), .imr_o(imr_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic do_init(input logic lt, input logic ae);
    init_level_trig = lt; init_auto_eoi = ae; init_pulse = 1'b1;
    @(negedge clk); init_pulse = 1'b0;
    settle();
  endtask

  task automatic set_mask(input logic [N-1:0] m);
    mask_data = m; mask_wr = 1'b1;
    @(negedge clk); mask_wr = 1'b0;
    settle();
  endtask

  task automatic set_smm(input logic v);
    smm_val = v; smm_wr = 1'b1;
    @(negedge clk); smm_wr = 1'b0;
    settle();
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] lvl);
    cmd_op = op; cmd_lvl = lvl; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    settle();
  endtask

  task automatic commit();
    ack_commit = 1'b1;
    @(negedge clk); ack_commit = 1'b0;
    settle();
  endtask

  task automatic final_ack();
    ack_final = 1'b1;
    @(negedge clk); ack_final = 1'b0;
    settle();
  endtask

  task automatic lines(input logic [N-1:0] v);
    irq_in = v;
    settle();
  endtask

  initial begin
    rst = 1'b1; irq_in = '0; init_pulse = 0; init_level_trig = 0; init_auto_eoi = 0;
    mask_wr = 0; mask_data = '0; smm_wr = 0; smm_val = 0; cmd_valid = 0;
    cmd_op = 0; cmd_lvl = 0; ack_commit = 0; ack_final = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1: reset state
    chk("R1 int after reset", int_o, 0);
    chk("R1 irr after reset", irr_o, 0);
    chk("R1 isr after reset", isr_o, 0);
    chk("R1 imr after reset", imr_o, 0);

    // R1: initialization clears mask, special mask and edge history
    set_mask(8'hFF);
    set_smm(1'b1);
    irq_in = 8'h02;
    do_init(1'b0, 1'b0);
    chk("R1 imr cleared by init", imr_o, 0);
    chk("R1 line high at init not latched", irr_o, 0);
    lines(8'h00);

    // R2 R3 R4 R5 R9: single-level sweep
    for (int i = 0; i < N; i++) begin
      lines(8'(1 << i));
      chk("R9 edge latch", irr_o, 1 << i);
      chk("R2 int for lone request", int_o, 1);
      chk("R3 winner", win_lvl, i);
      commit();
      chk("R4 ack level", ack_lvl, i);
      chk("R4 isr set", isr_o, 1 << i);
      chk("R9 held line not relatched", irr_o, 0);
      chk("R9 no int while held", int_o, 0);
      lines(8'h00);
      cmd(3'd1, 3'd0);
      chk("R5 nonspecific clear", isr_o, 0);
    end

    // R2 R6: full nesting over every in-service/request pair
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        lines(8'(1 << a));
        commit();
        lines(8'h00);
        lines(8'(1 << b));
        chk("R2 nesting", int_o, (b < a) ? 1 : 0);
        cmd(3'd2, 3'(a));
        chk("R6 specific clear", isr_o, 0);
        lines(8'h00);
      end
    end

    // R3: mask blocks only its own line
    lines(8'hFF);
    set_mask(8'h01);
    chk("R3 masked top level skipped", win_lvl, 1);
    chk("R3 lower level still raises int", int_o, 1);
    set_mask(8'hFE);
    chk("R3 unmasked top wins", win_lvl, 0);
    set_mask(8'hFF);
    chk("R3 all masked", int_o, 0);
    set_mask(8'h00);
    chk("R3 unmask restores int", int_o, 1);
    lines(8'h00);

    // R7: rotation sweep over every lowest level
    for (int n = 0; n < N; n++) begin
      do_init(1'b0, 1'b0);
      cmd(3'd5, 3'(n));
      lines(8'hFF);
      chk("R7 set-low winner", win_lvl, (n + 1) % N);
      commit();
      chk("R7 ack after set-low", ack_lvl, (n + 1) % N);
      cmd(3'd3, 3'd0);
      chk("R7 rotating eoi clears", isr_o, 0);
      chk("R7 winner after rotate", win_lvl, (n + 2) % N);
      commit();
      cmd(3'd5, 3'(n));
      chk("R7 set-low keeps isr", isr_o, 1 << ((n + 2) % N));
      lines(8'h00);
      cmd(3'd1, 3'd0);
    end

    // R7: specific rotate
    do_init(1'b0, 1'b0);
    lines(8'h40);
    commit();
    cmd(3'd4, 3'd6);
    chk("R7 specific rotate clears", isr_o, 0);
    lines(8'hC1);
    chk("R7 level after new lowest wins", win_lvl, 7);
    lines(8'h00);

    // R8 R5: special mask mode
    do_init(1'b0, 1'b0);
    lines(8'h04);
    commit();
    lines(8'h00);
    set_mask(8'h04);
    lines(8'h20);
    chk("R8 lower level blocked without smm", int_o, 0);
    set_smm(1'b1);
    chk("R8 lower level allowed with smm", int_o, 1);
    commit();
    chk("R8 nested isr", isr_o, 8'h24);
    lines(8'h00);
    cmd(3'd1, 3'd0);
    chk("R5 smm skips masked isr", isr_o, 8'h04);
    set_smm(1'b0);
    cmd(3'd1, 3'd0);
    chk("R5 clear remaining", isr_o, 0);

    // R11: commit with nothing due
    do_init(1'b0, 1'b0);
    commit();
    chk("R11 default level", ack_lvl, 7);
    chk("R11 no isr set", isr_o, 0);
    lines(8'h08);
    commit();
    lines(8'h00);
    lines(8'h40);
    chk("R11 lower request no int", int_o, 0);
    commit();
    chk("R11 default while nested", ack_lvl, 7);
    chk("R11 isr unchanged", isr_o, 8'h08);
    lines(8'h00);
    cmd(3'd1, 3'd0);

    // R10: level mode
    do_init(1'b1, 1'b0);
    lines(8'h10);
    chk("R10 level request", int_o, 1);
    commit();
    chk("R10 isr set", isr_o, 8'h10);
    chk("R10 relatched while high", irr_o, 8'h10);
    cmd(3'd1, 3'd0);
    chk("R10 int again after eoi", int_o, 1);
    lines(8'h00);
    chk("R10 irr drops with line", irr_o, 0);

    // R12: automatic end-of-interrupt and auto-rotate
    do_init(1'b0, 1'b1);
    lines(8'h08);
    commit();
    chk("R12 isr before final", isr_o, 8'h08);
    final_ack();
    chk("R12 final clears isr", isr_o, 0);
    lines(8'h00);
    lines(8'hFF);
    chk("R12 no rotate when flag clear", win_lvl, 0);
    cmd(3'd6, 3'd0);
    lines(8'h00);
    lines(8'h20);
    commit();
    final_ack();
    chk("R12 final clears with rotate", isr_o, 0);
    lines(8'h00);
    lines(8'hFF);
    chk("R12 auto-rotate winner", win_lvl, 6);
    lines(8'h00);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule